// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a locked configuration window that a host reaches through two byte-wide I/O locations. The lower location, selected by `addr_i = 0`, is the index port; the upper location, selected by `addr_i = 1`, is the data port.

After reset the window is closed. It opens only when a fixed four-byte key has been written to the index port. While it is open:
- an index write chooses the configuration register that the next data access reaches;
- data accesses then read or write that register.

A small set of global registers lives inside the block:
- a logical-device selector;
- a two-byte read-only identifier;
- a read-only revision byte;
- a lock register, which closes the window again.

Register numbers from 0x30 upward belong to the attached logical devices. For them the block forwards the following, and returns the device's read data:
- decoded read and write strobes;
- the selected register number;
- the current device selector;
- the write byte.

Every bus access is a single clock cycle. The read data is combinational while `rd_i` is high. Writes take effect at the rising clock edge that ends the cycle.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the port is locked (`unlocked_o` = 0), the device selector `ldn_o` is 0x00, and a read of either port returns 0xFF.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 to the index port in that order, with any data-port traffic in between, sets `unlocked_o` in the cycle after the fourth byte.
- R3: While locked, an index byte that does not match the expected key byte sends the matcher back to the first key byte. If the mismatching byte is 0x87, it counts as the first key byte, so for example 0x87 0x87 0x01 0x55 0x55 unlocks.
- R4: While locked, data-port writes change nothing: `ldn_o` holds, no device strobe fires, and a later read shows the old contents. Reads of either port return 0xFF.
- R5: While unlocked, an index write selects the register (shown on `reg_sel_o`), and a read of the index port returns the last index written.
- R6: Register 0x07 is the read/write device selector. Its value appears on `ldn_o` from the cycle after the data write.
- R7: Register 0x20 reads the high byte of CHIP_ID, 0x21 reads the low byte, and 0x22 reads CHIP_REV in bits 3:0 with bits 7:4 zero. Writes to these registers have no effect.
- R8: A data write of 0x02 to register 0x02 locks the port from the next cycle on. Any other value written to register 0x02 leaves the port unlocked.
- R9: With the port unlocked and the selected register at or above DEV_BASE (0x30), a data access raises `dev_wr_o` or `dev_rd_o` in that same cycle, and a read returns `dev_rdata_i`. Registers below DEV_BASE never raise a strobe and read the same whatever `ldn_o` holds.
- R10: Global registers below DEV_BASE other than 0x07, 0x20, 0x21 and 0x22 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| rd_i | input | 1 | Read cycle |
| wr_i | input | 1 | Write cycle |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte |
| unlocked_o | output | 1 | Configuration window is open |
| ldn_o | output | 8 | Current logical-device selector |
| reg_sel_o | output | 8 | Currently selected register number |
| dev_wr_o | output | 1 | Write strobe for a device register |
| dev_rd_o | output | 1 | Read strobe for a device register |
| dev_wdata_o | output | 8 | Write byte forwarded to the devices |
| dev_rdata_i | input | 8 | Read byte returned by the selected device |

## Verification
The hardest states to reach are the key matcher's recovery paths: a mismatch partway through the key, and a stray 0x87 that has to restart the match at the second step rather than at the first. Random traffic almost never produces four exact index bytes in a row. The stimulus therefore mixes directed broken and restarted key runs with random operations whose bytes are drawn from a pool weighted toward key, lock and register values. Complete key or lock sequences are also injected at random points, so locked and unlocked periods alternate throughout the run.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  localparam int KEY_LEN = 4;
  // entry key, element 0 is sent first
  localparam logic [KEY_LEN-1:0][7:0] KEY_SEQ = {8'h55, 8'h55, 8'h01, 8'h87};
  localparam logic [7:0] REG_LOCK  = 8'h02;
  localparam logic [7:0] LOCK_CODE = 8'h02;
  localparam logic [7:0] REG_LDN   = 8'h07;
  localparam logic [7:0] REG_ID_HI = 8'h20;
  localparam logic [7:0] REG_ID_LO = 8'h21;
  localparam logic [7:0] REG_REV   = 8'h22;
  localparam logic [7:0] RD_IDLE   = 8'hFF;
endpackage

// File: rtl/cfg_key_match.sv
`timescale 1ns/1ps
module cfg_key_match
  import cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       relock_i,
  output logic       unlocked_o
);
  localparam int STEP_W = $clog2(KEY_LEN);

  logic [STEP_W-1:0] step_q;
  logic              unl_q;
  logic              hit;

  assign hit = (wdata_i == KEY_SEQ[step_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      unl_q  <= 1'b0;
    end else if (relock_i) begin
      step_q <= '0;
      unl_q  <= 1'b0;
    end else if (!unl_q && idx_wr_i) begin
      if (hit) begin
        if (step_q == STEP_W'(KEY_LEN-1)) begin
          step_q <= '0;
          unl_q  <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (wdata_i == KEY_SEQ[0]) begin
        step_q <= STEP_W'(1);  // stray first byte restarts at step two
      end else begin
        step_q <= '0;
      end
    end
  end

  assign unlocked_o = unl_q;

  AST_UNLOCK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unl_q) |-> $past(idx_wr_i && wdata_i == KEY_SEQ[KEY_LEN-1])); // R2
  AST_KEY_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unl_q && !relock_i && idx_wr_i && !hit && wdata_i != KEY_SEQ[0]) |=> step_q == '0); // R3
  AST_KEY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unl_q && !relock_i && idx_wr_i && !hit && wdata_i == KEY_SEQ[0]) |=> step_q == STEP_W'(1)); // R3
endmodule

// File: rtl/cfg_glob_regs.sv
`timescale 1ns/1ps
module cfg_glob_regs
  import cfg_pkg::*;
#(
  parameter logic [7:0] DEV_BASE = 8'h30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       unlocked_i,
  input  logic       addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] idx_o,
  output logic [7:0] ldn_o,
  output logic       relock_o,
  output logic       dev_wr_o,
  output logic       dev_rd_o
);
  logic [7:0] idx_q, ldn_q;
  logic       idx_wr, dat_wr, dev_sel;

  assign idx_wr  = unlocked_i && wr_i && !addr_i;
  assign dat_wr  = unlocked_i && wr_i && addr_i;
  assign dev_sel = (idx_q >= DEV_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata_i;
      if (dat_wr && idx_q == REG_LDN) ldn_q <= wdata_i;
    end
  end

  assign relock_o = dat_wr && idx_q == REG_LOCK && wdata_i == LOCK_CODE;
  assign dev_wr_o = dat_wr && dev_sel;
  assign dev_rd_o = unlocked_i && rd_i && addr_i && dev_sel;
  assign idx_o    = idx_q;
  assign ldn_o    = ldn_q;

  AST_LOW_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q < DEV_BASE) |-> !(dev_wr_o || dev_rd_o)); // R9
  AST_IDX_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i) |=> $stable(idx_q)); // R5
endmodule

// File: rtl/cfg_rd_mux.sv
`timescale 1ns/1ps
module cfg_rd_mux
  import cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h5,
  parameter logic [7:0]  DEV_BASE = 8'h30
) (
  input  logic       unlocked_i,
  input  logic       addr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] ldn_i,
  input  logic [7:0] dev_rdata_i,
  output logic [7:0] rdata_o
);
  always_comb begin
    if (!unlocked_i)  rdata_o = RD_IDLE;
    else if (!addr_i) rdata_o = idx_i;
    else begin
      unique case (idx_i)
        REG_LDN:   rdata_o = ldn_i;
        REG_ID_HI: rdata_o = CHIP_ID[15:8];
        REG_ID_LO: rdata_o = CHIP_ID[7:0];
        REG_REV:   rdata_o = {4'h0, CHIP_REV};
        default:   rdata_o = (idx_i >= DEV_BASE) ? dev_rdata_i : 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_unlock.sv
`timescale 1ns/1ps
module cfg_port_unlock
  import cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h5,
  parameter logic [7:0]  DEV_BASE = 8'h30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       unlocked_o,
  output logic [7:0] ldn_o,
  output logic [7:0] reg_sel_o,
  output logic       dev_wr_o,
  output logic       dev_rd_o,
  output logic [7:0] dev_wdata_o,
  input  logic [7:0] dev_rdata_i
);
  logic       unl, relock;
  logic [7:0] idx, ldn;

  cfg_key_match u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (wr_i && !addr_i),
    .wdata_i    (wdata_i),
    .relock_i   (relock),
    .unlocked_o (unl)
  );

  cfg_glob_regs #(.DEV_BASE(DEV_BASE)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unlocked_i (unl),
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .idx_o      (idx),
    .ldn_o      (ldn),
    .relock_o   (relock),
    .dev_wr_o   (dev_wr_o),
    .dev_rd_o   (dev_rd_o)
  );

  cfg_rd_mux #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .DEV_BASE(DEV_BASE)) u_mux (
    .unlocked_i  (unl),
    .addr_i      (addr_i),
    .idx_i       (idx),
    .ldn_i       (ldn),
    .dev_rdata_i (dev_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign unlocked_o  = unl;
  assign ldn_o       = ldn;
  assign reg_sel_o   = idx;
  assign dev_wdata_o = wdata_i;

  AST_LOCKED_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && rd_i) |-> rdata_o == RD_IDLE); // R4
  AST_NO_STROBE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |-> !(dev_wr_o || dev_rd_o)); // R4
  AST_LDN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |=> $stable(ldn_o)); // R4
  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && wr_i && addr_i && reg_sel_o == REG_LOCK && wdata_i == LOCK_CODE)
      |=> !unlocked_o); // R8
endmodule

// File: tb/sim_cfg_port_unlock.sv
`timescale 1ns/1ps
module sim_cfg_port_unlock;
  localparam logic [15:0] ID  = 16'h8728;
  localparam logic [3:0]  REV = 4'h5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, dev_rdata = '0;
  logic [7:0] rdata, ldn, reg_sel, dev_wdata;
  logic unlocked, dev_wr, dev_rd;

  always #4 clk = ~clk;

  cfg_port_unlock #(.CHIP_ID(ID), .CHIP_REV(REV), .DEV_BASE(8'h30)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .unlocked_o(unlocked), .ldn_o(ldn),
    .reg_sel_o(reg_sel), .dev_wr_o(dev_wr), .dev_rd_o(dev_rd),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit m_unl = 0;
  int m_step = 0;
  logic [7:0] m_idx = 0, m_ldn = 0;
  logic [7:0] key [4] = '{8'h87, 8'h01, 8'h55, 8'h55};

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(bit a, logic [7:0] dv);
    if (!m_unl) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return ID[15:8];
      8'h21: return ID[7:0];
      8'h22: return {4'h0, REV};
      default: return (m_idx >= 8'h30) ? dv : 8'h00;
    endcase
  endfunction

  task automatic bus_wr(bit a, logic [7:0] d, string req);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1;
    chk(req, "dev_wr", {15'b0, dev_wr}, {15'b0, m_unl && a && m_idx >= 8'h30});
    if (m_unl) begin
      if (!a) m_idx = d;
      else begin
        if (m_idx == 8'h07) m_ldn = d;
        if (m_idx == 8'h02 && d == 8'h02) begin m_unl = 0; m_step = 0; end
      end
    end else if (!a) begin
      if (d == key[m_step]) begin
        if (m_step == 3) begin m_unl = 1; m_step = 0; end
        else m_step++;
      end else m_step = (d == 8'h87) ? 1 : 0;
    end
    @(negedge clk);
    wr = 1'b0;
    chk(req, "unlocked", {15'b0, unlocked}, {15'b0, m_unl});
    chk(req, "ldn", {8'b0, ldn}, {8'b0, m_ldn});
  endtask

  task automatic bus_rd(bit a, string req);
    logic [7:0] dv;
    @(negedge clk);
    dv = 8'($urandom);
    dev_rdata = dv; addr = a; rd = 1'b1;
    #1;
    chk(req, "rdata", {8'b0, rdata}, {8'b0, exp_rd(a, dv)});
    chk(req, "dev_rd", {15'b0, dev_rd}, {15'b0, m_unl && a && m_idx >= 8'h30});
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic send_key(string req);
    for (int i = 0; i < 4; i++) bus_wr(1'b0, key[i], req);
  endtask

  task automatic relock(string req);
    bus_wr(1'b0, 8'h02, req);
    bus_wr(1'b1, 8'h02, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] pool [10];
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "unlocked", {15'b0, unlocked}, 16'h0);
    chk("R1", "ldn", {8'b0, ldn}, 16'h0);
    bus_rd(1'b1, "R1");
    bus_rd(1'b0, "R1");
    // R4 locked writes ignored
    bus_wr(1'b1, 8'h5A, "R4");
    bus_rd(1'b1, "R4");
    // R3 broken key, then 0x87 restart
    bus_wr(1'b0, 8'h87, "R3"); bus_wr(1'b0, 8'h01, "R3");
    bus_wr(1'b0, 8'h55, "R3"); bus_wr(1'b0, 8'h00, "R3");
    bus_wr(1'b0, 8'h55, "R3");
    bus_wr(1'b0, 8'h87, "R3"); bus_wr(1'b0, 8'h87, "R3");
    bus_wr(1'b0, 8'h01, "R3"); bus_wr(1'b1, 8'h33, "R2");
    bus_wr(1'b0, 8'h55, "R3"); bus_wr(1'b0, 8'h55, "R3");
    chk("R3", "unlocked after restart", {15'b0, unlocked}, 16'h1);
    // R5 index readback
    bus_wr(1'b0, 8'h22, "R5");
    chk("R5", "reg_sel", {8'b0, reg_sel}, 16'h0022);
    bus_rd(1'b0, "R5");
    // R7 identification
    bus_rd(1'b1, "R7");
    bus_wr(1'b1, 8'hEE, "R7");
    bus_rd(1'b1, "R7");
    bus_wr(1'b0, 8'h20, "R7"); bus_rd(1'b1, "R7");
    bus_wr(1'b0, 8'h21, "R7"); bus_rd(1'b1, "R7");
    // R6 device selector
    bus_wr(1'b0, 8'h07, "R6"); bus_wr(1'b1, 8'h0B, "R6");
    bus_rd(1'b1, "R6");
    // R9 device window and globals independent of ldn
    bus_wr(1'b0, 8'h30, "R9"); bus_wr(1'b1, 8'h44, "R9");
    bus_rd(1'b1, "R9");
    bus_wr(1'b0, 8'hFF, "R9"); bus_rd(1'b1, "R9");
    bus_wr(1'b0, 8'h2F, "R9"); bus_wr(1'b1, 8'h12, "R9"); bus_rd(1'b1, "R9");
    bus_wr(1'b0, 8'h20, "R9"); bus_rd(1'b1, "R9");
    // R10 unimplemented global
    bus_wr(1'b0, 8'h10, "R10"); bus_wr(1'b1, 8'hAA, "R10");
    bus_rd(1'b1, "R10");
    // R8 lock register
    bus_wr(1'b0, 8'h02, "R8"); bus_wr(1'b1, 8'h03, "R8");
    chk("R8", "still unlocked", {15'b0, unlocked}, 16'h1);
    bus_wr(1'b1, 8'h02, "R8");
    chk("R8", "locked", {15'b0, unlocked}, 16'h0);
    bus_rd(1'b1, "R8");
    // R3 restart from mid key, R2 plain key
    bus_wr(1'b0, 8'h87, "R3"); bus_wr(1'b0, 8'h01, "R3");
    send_key("R3");
    relock("R8");
    send_key("R2");
    relock("R8");
    // random phase
    pool = '{8'h87, 8'h01, 8'h55, 8'h55, 8'h02, 8'h07, 8'h20, 8'h22, 8'h30, 8'h00};
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [7:0] d;
      r = $urandom % 100;
      d = pool[$urandom % 10];
      if (d == 8'h00) d = 8'($urandom);
      if (r < 6 && !m_unl) send_key("R2");
      else if (r < 9 && m_unl) relock("R8");
      else if (r < 55) bus_wr(1'($urandom), d, "RND(R3,R4,R6)");
      else bus_rd(1'($urandom), "RND(R5,R7,R9)");
    end
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule